// File: doc/BRIEF.md
# Byte-to-Word Card Data FIFO Engine

This block sits between a bus-facing word FIFO and a card data port that moves one byte at a time. Software loads a 16-bit transfer length, then sets the enable bit together with a direction bit. In the receive direction the engine takes bytes from the card while the card signals ready. It packs them into 32-bit words, lowest byte lane first, and pushes each finished word into a 16-word FIFO that the bus pops. In the transmit direction the bus pushes words and the engine sends them to the card one byte at a time, low byte first.

A remaining-byte counter tracks progress. A rounded-up word count is derived from it. When the counter reaches zero, a partly filled receive word is flushed into the FIFO and two sticky end flags are raised. The engine drops its own enable once the counter is zero and the FIFO has drained. A 22-bit status word carries the end flags and one group of FIFO level flags. The direction bit selects which group.

Top module: `bwx_engine`

## Requirements
- R1: After reset the status word, enable, remaining-byte count, word count and FIFO level are all zero.
- R2: A control write with enable set loads the remaining-byte count from the length register. The word count output always equals (remaining bytes + 3) / 4, rounded down. This gives 4 for 13 bytes and 0x4000 for 0xFFFF bytes.
- R3: In the receive direction (direction bit 1), one byte moves per cycle, and only while all three hold: the card is ready, the count is nonzero and the FIFO holds fewer than 16 words. Each byte moved asserts card_rd and decrements the count by one. Byte n of a word lands in bits 8n+7:8n.
- R4: When the last receive byte is taken, the partly filled word is pushed with its unused upper lanes zero.
- R5: In the transmit direction (direction bit 0), each FIFO word goes to the card in the order bits 7:0, 15:8, 23:16, 31:24, one byte per ready cycle. The count drops by one per byte. Transfer pauses while no byte is held and the FIFO is empty.
- R6: While enabled with a zero count, status bit 8 (data end) and bit 10 (block end) are set. Both stay set until end_clr.
- R7: When enabled with a zero count and an empty FIFO, the enable clears on the next cycle. All level flags read zero whenever the count is zero and the FIFO is empty.
- R8: Otherwise the level flags follow the FIFO word count c: active always; empty if c=0; data available if c>0; full if c=16; transmit half-empty if c<=8; receive half-full if c>=8.
- R9: Only one flag group is reported. Receive uses bits 13 active, 15 half-full, 17 full, 19 empty and 21 available. Transmit uses bits 12 active, 14 half-empty, 16 full, 18 empty and 20 available.
- R10: The FIFO holds 16 words and returns them in push order across pointer wrap.
- R11: A bus pop from an empty FIFO, or while the direction is transmit, returns zero. A bus push into a full FIFO, or while the direction is receive, is dropped. Each of these pulses err for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| len_we | input | 1 | Write strobe for the length register |
| len_wdata | input | 16 | Transfer length in bytes |
| ctrl_we | input | 1 | Write strobe for enable and direction |
| ctrl_en | input | 1 | Enable value; 1 also reloads the count |
| ctrl_dir | input | 1 | Direction value, 1 = receive from card |
| end_clr | input | 1 | Clears both end flags |
| bus_push | input | 1 | Bus pushes one word |
| bus_wdata | input | 32 | Word pushed by the bus |
| bus_pop | input | 1 | Bus pops one word |
| bus_rdata | output | 32 | Popped word, valid the cycle after bus_pop |
| card_rdy | input | 1 | Card can supply or accept a byte |
| card_rd | output | 1 | A card byte is taken this cycle |
| card_rd_data | input | 8 | Byte offered by the card |
| card_wr | output | 1 | A byte is sent to the card this cycle |
| card_wr_data | output | 8 | Byte sent to the card |
| xfer_en | output | 1 | Current enable bit |
| xfer_dir | output | 1 | Current direction bit |
| byte_cnt | output | 16 | Remaining byte count |
| word_cnt | output | 15 | Remaining count in words, rounded up |
| fifo_level | output | 5 | Words held in the FIFO |
| stat | output | 22 | End flags and level flags |
| err | output | 1 | One-cycle pulse on a dropped push or empty/misdirected pop |

## Verification
The bench goes after receive lengths that are not multiples of four. A design that skipped the final flush would leave the last one to three bytes stranded, and one that did not clear the lanes would leak stale bytes into the upper part of the word. It fills the FIFO to exactly 16 words with more receive data pending. This catches an engine that overwrites a full FIFO or fails to resume after pops. Every fill level from 1 to 16 is compared against the half and full thresholds; an off-by-one comparison shows up at level 8 or 16. Transmit runs check the byte order, the pause on an empty FIFO and the drop of a 17th push. A misordered unpacker, a premature end flag or an enable that never clears would each show up as a byte or status mismatch.

// File: rtl/bwx_pkg.sv
package bwx_pkg;
    localparam int STAT_W     = 22;
    localparam int B_DEND     = 8;
    localparam int B_BEND     = 10;
    localparam int B_TX_ACT   = 12;
    localparam int B_RX_ACT   = 13;
    localparam int B_TX_HALF  = 14;
    localparam int B_RX_HALF  = 15;
    localparam int B_TX_FULL  = 16;
    localparam int B_RX_FULL  = 17;
    localparam int B_TX_EMPTY = 18;
    localparam int B_RX_EMPTY = 19;
    localparam int B_TX_AVL   = 20;
    localparam int B_RX_AVL   = 21;

    localparam logic [STAT_W-1:0] RX_GROUP = STAT_W'(32'h002A_A000);
    localparam logic [STAT_W-1:0] TX_GROUP = STAT_W'(32'h0015_5000);

    typedef struct packed {
        logic act;
        logic half;
        logic full;
        logic empty;
        logic avail;
    } lvl_t;
endpackage

// File: rtl/bwx_fifo.sv
module bwx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        p_d = p_q;
        if (push) p_d.wr = (p_q.wr == AW'(DEPTH - 1)) ? '0 : p_q.wr + AW'(1);
        if (pop)  p_d.rd = (p_q.rd == AW'(DEPTH - 1)) ? '0 : p_q.rd + AW'(1);
        case ({push, pop})
            2'b10:   p_d.cnt = p_q.cnt + CW'(1);
            2'b01:   p_d.cnt = p_q.cnt - CW'(1);
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[p_q.wr] <= wdata;
    end

    assign head  = mem_q[p_q.rd];
    assign count = p_q.cnt;

    assert_no_push_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (p_q.cnt != CW'(DEPTH)));
    assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (p_q.cnt != '0));
    assert_level_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (p_q.cnt == $past(p_q.cnt) || p_q.cnt == $past(p_q.cnt) + CW'(1)
                  || p_q.cnt == $past(p_q.cnt) - CW'(1)));
endmodule

// File: rtl/bwx_flags.sv
module bwx_flags
    import bwx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic              dir,
    input  logic              bytes_zero,
    input  logic [CW-1:0]     level,
    input  logic              data_end,
    input  logic              blk_end,
    output logic [STAT_W-1:0] stat
);
    lvl_t rx, tx;
    logic idle;

    always_comb begin
        idle     = bytes_zero && (level == '0);
        rx.act   = 1'b1;
        rx.empty = (level == '0);
        rx.avail = (level != '0);
        rx.full  = (level == CW'(DEPTH));
        rx.half  = (level >= CW'(HALF));
        tx       = rx;
        tx.half  = (level <= CW'(HALF));

        stat         = '0;
        stat[B_DEND] = data_end;
        stat[B_BEND] = blk_end;
        if (!idle) begin
            if (dir) begin
                stat[B_RX_ACT]   = rx.act;
                stat[B_RX_HALF]  = rx.half;
                stat[B_RX_FULL]  = rx.full;
                stat[B_RX_EMPTY] = rx.empty;
                stat[B_RX_AVL]   = rx.avail;
            end else begin
                stat[B_TX_ACT]   = tx.act;
                stat[B_TX_HALF]  = tx.half;
                stat[B_TX_FULL]  = tx.full;
                stat[B_TX_EMPTY] = tx.empty;
                stat[B_TX_AVL]   = tx.avail;
            end
        end
    end
endmodule

// File: rtl/bwx_engine.sv
module bwx_engine
    import bwx_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int LEN_W = 16,
    localparam int BPW  = W / 8,
    localparam int LW   = $clog2(BPW),
    localparam int TNW  = $clog2(BPW + 1),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              ctrl_we,
    input  logic              ctrl_en,
    input  logic              ctrl_dir,
    input  logic              end_clr,
    input  logic              bus_push,
    input  logic [W-1:0]      bus_wdata,
    input  logic              bus_pop,
    output logic [W-1:0]      bus_rdata,
    input  logic              card_rdy,
    output logic              card_rd,
    input  logic [7:0]        card_rd_data,
    output logic              card_wr,
    output logic [7:0]        card_wr_data,
    output logic              xfer_en,
    output logic              xfer_dir,
    output logic [LEN_W-1:0]  byte_cnt,
    output logic [LEN_W-2:0]  word_cnt,
    output logic [CW-1:0]     fifo_level,
    output logic [STAT_W-1:0] stat,
    output logic              err
);
    typedef struct packed {
        logic             en;
        logic             dir;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] bcnt;
        logic [W-1:0]     pack;
        logic [LW-1:0]    lane;
        logic [W-1:0]     tx_sh;
        logic [TNW-1:0]   tx_n;
        logic             dend;
        logic             bend;
        logic [W-1:0]     rdata;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    logic          fifo_push, fifo_pop;
    logic [W-1:0]  fifo_wdata, fifo_head;
    logic [CW-1:0] fcnt;
    logic          fifo_full, fifo_empty, cnt_zero;
    logic          rx_go, tx_go, tx_need;
    logic [W-1:0]  merged;

    bwx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (fcnt)
    );

    always_comb begin
        s_d          = s_q;
        s_d.err      = 1'b0;
        fifo_push    = 1'b0;
        fifo_pop     = 1'b0;
        fifo_wdata   = '0;
        card_rd      = 1'b0;
        card_wr      = 1'b0;
        card_wr_data = '0;

        fifo_full  = (fcnt == CW'(DEPTH));
        fifo_empty = (fcnt == '0);
        cnt_zero   = (s_q.bcnt == '0);
        tx_need    = (s_q.tx_n == '0);
        rx_go      = s_q.en && s_q.dir && !cnt_zero && card_rdy && !fifo_full;
        tx_go      = s_q.en && !s_q.dir && !cnt_zero && card_rdy && !(tx_need && fifo_empty);
        merged     = s_q.pack | (W'(card_rd_data) << {s_q.lane, 3'b000});

        if (len_we) s_d.len = len_wdata;

        // receive: pack card bytes low lane first, flush on last byte
        if (rx_go) begin
            card_rd  = 1'b1;
            s_d.bcnt = s_q.bcnt - LEN_W'(1);
            if (s_q.lane == LW'(BPW - 1) || s_q.bcnt == LEN_W'(1)) begin
                fifo_push  = 1'b1;
                fifo_wdata = merged;
                s_d.pack   = '0;
                s_d.lane   = '0;
            end else begin
                s_d.pack = merged;
                s_d.lane = s_q.lane + LW'(1);
            end
        end

        // transmit: unpack FIFO words low byte first
        if (tx_go) begin
            card_wr  = 1'b1;
            s_d.bcnt = s_q.bcnt - LEN_W'(1);
            if (tx_need) begin
                fifo_pop     = 1'b1;
                card_wr_data = fifo_head[7:0];
                s_d.tx_sh    = fifo_head >> 8;
                s_d.tx_n     = TNW'(BPW - 1);
            end else begin
                card_wr_data = s_q.tx_sh[7:0];
                s_d.tx_sh    = s_q.tx_sh >> 8;
                s_d.tx_n     = s_q.tx_n - TNW'(1);
            end
        end

        // bus side: pushes only when transmitting, pops only when receiving
        if (bus_push) begin
            if (s_q.dir || fifo_full) begin
                s_d.err = 1'b1;
            end else begin
                fifo_push  = 1'b1;
                fifo_wdata = bus_wdata;
            end
        end
        if (bus_pop) begin
            if (!s_q.dir || fifo_empty) begin
                s_d.err   = 1'b1;
                s_d.rdata = '0;
            end else begin
                fifo_pop  = 1'b1;
                s_d.rdata = fifo_head;
            end
        end

        // end flags and self-clearing enable
        if (end_clr) begin
            s_d.dend = 1'b0;
            s_d.bend = 1'b0;
        end
        if (s_q.en && cnt_zero) begin
            s_d.dend = 1'b1;
            s_d.bend = 1'b1;
            if (fifo_empty) s_d.en = 1'b0;
        end

        if (ctrl_we) begin
            s_d.en  = ctrl_en;
            s_d.dir = ctrl_dir;
            if (ctrl_en) begin
                s_d.bcnt = s_q.len;
                s_d.pack = '0;
                s_d.lane = '0;
                s_d.tx_n = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bwx_flags #(.DEPTH(DEPTH)) u_flags (
        .dir        (s_q.dir),
        .bytes_zero (s_q.bcnt == '0),
        .level      (fcnt),
        .data_end   (s_q.dend),
        .blk_end    (s_q.bend),
        .stat       (stat)
    );

    assign bus_rdata  = s_q.rdata;
    assign err        = s_q.err;
    assign xfer_en    = s_q.en;
    assign xfer_dir   = s_q.dir;
    assign byte_cnt   = s_q.bcnt;
    assign word_cnt   = {1'b0, s_q.bcnt[LEN_W-1:2]} + (LEN_W-1)'(|s_q.bcnt[1:0]);
    assign fifo_level = fcnt;

    assert_bcnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> (s_q.bcnt == $past(s_q.bcnt) || s_q.bcnt == $past(s_q.bcnt) - LEN_W'(1)));
    assert_en_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && s_q.bcnt == '0 && fcnt == '0 && !ctrl_we) |=> !xfer_en);
    assert_end_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && s_q.bcnt == '0) |=> (stat[B_DEND] && stat[B_BEND]));
    assert_one_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(stat & RX_GROUP)) && (|(stat & TX_GROUP))));
    assert_last_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rd && s_q.bcnt == LEN_W'(1) && !bus_pop) |=> (fcnt == $past(fcnt) + CW'(1)));
endmodule

// File: tb/tb_bwx_engine.sv
module tb_bwx_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        len_we = 0, ctrl_we = 0, ctrl_en = 0, ctrl_dir = 0, end_clr = 0;
    logic        bus_push = 0, bus_pop = 0, card_rdy = 0;
    logic [15:0] len_wdata = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        card_rd, card_wr, xfer_en, xfer_dir, err;
    logic [7:0]  card_rd_data, card_wr_data;
    logic [15:0] byte_cnt;
    logic [14:0] word_cnt;
    logic [4:0]  fifo_level;
    logic [21:0] stat;

    int n_chk = 0, n_bad = 0, rx_idx = 0, nwr = 0, tx_base = 0;
    bit done = 0;
    logic [7:0] got [256];

    always #5 clk = ~clk;

    bwx_engine dut (.*);

    function automatic logic [7:0] rxb(int i);
        return 8'(i * 37 + 11);
    endfunction
    function automatic logic [31:0] txw(int k);
        return 32'(k * 32'h0103_0507 + 32'h80C0_E0F1);
    endfunction
    function automatic logic [31:0] rx_word(int st, int len, int k);
        logic [31:0] w;
        w = '0;
        for (int j = 0; j < 4; j++)
            if (4 * k + j < len) w = w | (32'(rxb(st + 4 * k + j)) << (8 * j));
        return w;
    endfunction
    function automatic logic [21:0] exp_stat(bit dir, int bc, int fc, bit ends);
        logic [21:0] s;
        s = '0;
        if (ends) begin s[8] = 1; s[10] = 1; end
        if (!(bc == 0 && fc == 0)) begin
            if (dir) begin
                s[13] = 1; s[15] = (fc >= 8); s[17] = (fc == 16);
                s[19] = (fc == 0); s[21] = (fc != 0);
            end else begin
                s[12] = 1; s[14] = (fc <= 8); s[16] = (fc == 16);
                s[18] = (fc == 0); s[20] = (fc != 0);
            end
        end
        return s;
    endfunction

    assign card_rd_data = rxb(rx_idx);
    always @(posedge clk) begin
        if (card_rd) rx_idx <= rx_idx + 1;
        if (card_wr) begin got[nwr % 256] <= card_wr_data; nwr <= nwr + 1; end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic set_len(int l);
        len_we = 1; len_wdata = 16'(l); idle(1); len_we = 0;
    endtask
    task automatic ctrl(bit en, bit dir);
        ctrl_we = 1; ctrl_en = en; ctrl_dir = dir; idle(1); ctrl_we = 0;
    endtask
    task automatic clr_end();
        end_clr = 1; idle(1); end_clr = 0;
    endtask
    task automatic push(logic [31:0] w, output logic e);
        bus_push = 1; bus_wdata = w; idle(1); bus_push = 0; e = err;
    endtask
    task automatic pop(output logic [31:0] d, output logic e);
        bus_pop = 1; idle(1); bus_pop = 0; d = bus_rdata; e = err;
    endtask

    task automatic rx_run(int len);
        int st, nw;
        logic [31:0] d;
        logic e;
        st = rx_idx; nw = (len + 3) / 4;
        set_len(len); card_rdy = 1; ctrl(1, 1);
        idle(len + 4);
        check("R3", "rx bytes taken", 32'(rx_idx - st), 32'(len));
        check("R3", "rx count done", 32'(byte_cnt), 0);
        check("R10", "rx level", 32'(fifo_level), 32'(nw));
        check("R8", "rx flags", 32'(stat), 32'(exp_stat(1, 0, nw, 1)));
        for (int k = 0; k < nw; k++) begin
            pop(d, e);
            check("R4", "rx word", d, rx_word(st, len, k));
        end
        idle(1);
        check("R7", "rx enable off", 32'(xfer_en), 0);
        check("R7", "rx flags idle", 32'(stat), 32'h500);
        clr_end();
        check("R6", "end cleared", 32'(stat), 0);
    endtask

    task automatic tx_run(int len);
        int nw, st;
        logic e;
        nw = (len + 3) / 4; st = nwr;
        card_rdy = 0; set_len(len); ctrl(1, 0);
        for (int k = 0; k < nw; k++) push(txw(tx_base + k), e);
        check("R10", "tx level", 32'(fifo_level), 32'(nw));
        check("R9", "tx flags", 32'(stat), 32'(exp_stat(0, len, nw, 0)));
        card_rdy = 1; idle(len + 4);
        check("R5", "tx bytes sent", 32'(nwr - st), 32'(len));
        for (int i = 0; i < len; i++)
            check("R5", "tx byte", 32'(got[(st + i) % 256]), 32'(8'(txw(tx_base + i / 4) >> (8 * (i % 4)))));
        check("R7", "tx enable off", 32'(xfer_en), 0);
        check("R6", "tx end flags", 32'(stat), 32'h500);
        clr_end();
        tx_base += nw;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        int st;
        idle(3); rst_n = 1; idle(1);
        // R1 reset state
        check("R1", "stat", 32'(stat), 0);
        check("R1", "enable", 32'(xfer_en), 0);
        check("R1", "byte count", 32'(byte_cnt), 0);
        check("R1", "word count", 32'(word_cnt), 0);
        check("R1", "level", 32'(fifo_level), 0);

        // R2 count load and word count
        card_rdy = 0; set_len(13); ctrl(1, 1);
        check("R2", "load 13", 32'(byte_cnt), 13);
        check("R2", "words 13", 32'(word_cnt), 4);
        set_len(16'hFFFF); ctrl(1, 1);
        check("R2", "load max", 32'(byte_cnt), 32'hFFFF);
        check("R2", "words max", 32'(word_cnt), 32'h4000);
        ctrl(0, 1);

        // R3 card ready gating
        set_len(8); ctrl(1, 1); idle(5);
        check("R3", "stalled count", 32'(byte_cnt), 8);
        check("R8", "stalled flags", 32'(stat), 32'(exp_stat(1, 8, 0, 0)));
        st = rx_idx; card_rdy = 1; idle(2);
        check("R3", "two bytes", 32'(byte_cnt), 6);
        idle(8);
        for (int k = 0; k < 2; k++) begin
            pop(d, e);
            check("R3", "gated word", d, rx_word(st, 8, k));
        end
        idle(1); clr_end();

        // receive sweep, including partial words and every fill level
        for (int l = 0; l <= 20; l++) rx_run(l);
        for (int n = 6; n <= 16; n++) rx_run(4 * n);
        rx_run(33); rx_run(63);

        // R3 full FIFO stall then resume
        st = rx_idx; set_len(80); card_rdy = 1; ctrl(1, 1); idle(80);
        check("R3", "full stall count", 32'(byte_cnt), 16);
        check("R8", "full flags", 32'(stat), 32'(exp_stat(1, 16, 16, 0)));
        for (int k = 0; k < 16; k++) begin
            pop(d, e);
            check("R10", "wrap word", d, rx_word(st, 80, k));
        end
        idle(30);
        for (int k = 16; k < 20; k++) begin
            pop(d, e);
            check("R10", "wrap word tail", d, rx_word(st, 80, k));
        end
        idle(1);
        check("R7", "full run done", 32'(xfer_en), 0);
        clr_end();

        // transmit sweep
        for (int l = 1; l <= 16; l++) tx_run(l);
        tx_run(61); tx_run(64);

        // R5 transmit pauses on empty FIFO
        st = nwr; card_rdy = 1; set_len(8); ctrl(1, 0);
        push(txw(tx_base), e); idle(6);
        check("R5", "pause count", 32'(byte_cnt), 4);
        check("R8", "pause flags", 32'(stat), 32'(exp_stat(0, 4, 0, 0)));
        push(txw(tx_base + 1), e); idle(6);
        check("R5", "resume count", 32'(byte_cnt), 0);
        check("R7", "resume enable", 32'(xfer_en), 0);
        for (int i = 0; i < 8; i++)
            check("R5", "pause byte", 32'(got[(st + i) % 256]), 32'(8'(txw(tx_base + i / 4) >> (8 * (i % 4)))));
        tx_base += 2; clr_end();

        // R11 push into full FIFO, misdirected and empty pops
        card_rdy = 0; set_len(68); ctrl(1, 0);
        for (int k = 0; k < 16; k++) push(txw(tx_base + k), e);
        push(32'hDEAD_BEEF, e);
        check("R11", "full push err", 32'(e), 1);
        check("R11", "full level kept", 32'(fifo_level), 16);
        check("R8", "tx full flags", 32'(stat), 32'(exp_stat(0, 68, 16, 0)));
        pop(d, e);
        check("R11", "tx-dir pop data", d, 0);
        check("R11", "tx-dir pop err", 32'(e), 1);
        check("R11", "tx-dir pop level", 32'(fifo_level), 16);
        st = nwr; card_rdy = 1; idle(70);
        check("R11", "dropped word unsent", 32'(nwr - st), 64);
        check("R5", "leftover count", 32'(byte_cnt), 4);
        check("R5", "last sent byte", 32'(got[(st + 63) % 256]), 32'(txw(tx_base + 15) >> 24));
        tx_base += 16;
        ctrl(0, 1);
        pop(d, e);
        check("R11", "empty pop data", d, 0);
        check("R11", "empty pop err", 32'(e), 1);
        push(32'h1234_5678, e);
        check("R11", "rx-dir push err", 32'(e), 1);
        check("R11", "rx-dir push level", 32'(fifo_level), 0);
        idle(1);
        check("R11", "err one cycle", 32'(err), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule